// File: doc/BRIEF.md
# HDB3 Receive Decoder with Coding-Violation Detection

This block takes a received bipolar line split onto two rails and turns it into a single NRZ bit stream. A rail input of `pos_i=1, neg_i=0` is a positive mark. `pos_i=0, neg_i=1` is a negative mark. Both low is a space. Both high is a double mark, which a healthy line never produces. The decoder remembers the polarity of the last mark it accepted. A mark that repeats that polarity is a bipolar violation. When such a violation closes a four-bit zero-substitution group, the whole group is turned back into four zeros. Any other violation raises a one-cycle coding-violation pulse and is decoded as a one.

To undo a substitution the block must rewrite bits it has already received. For this reason the decoded stream passes through a four-stage delay line, and the decoded data lags the rails by four bit periods. The received rails are also returned, one cycle late, for equipment that needs the raw marks. When the codec-enable input is low, the decoder is bypassed. The positive rail then goes straight to the data output, the violation output stays low, and the decoder returns to its post-reset condition. By default all outputs change on the falling clock edge, so a downstream stage can take them on the rising edge.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: While `rst` is high, `nrz_o`, `rail_p_o`, `rail_n_o` and `cv_o` are low. After reset the last-mark polarity is negative, and the first mark of either polarity never raises `cv_o`.
- R2: With the codec enabled, a mark whose polarity differs from the last accepted mark decodes as a one, and a space decodes as a zero. A bit sampled at rising edge k appears on `nrz_o` from the falling edge after rising edge k+3.
- R3: A mark that repeats the last polarity and follows three spaces (a zero-zero-zero-violation group) decodes, together with those three spaces, as four zeros, with no `cv_o` pulse.
- R4: A mark that repeats the last polarity, where the mark three bits earlier had that same polarity and the two bits between were spaces (a balancing-zero-zero-violation group), decodes together with those three bits as four zeros, with no `cv_o` pulse.
- R5: A repeated-polarity mark that fits neither R3 nor R4 decodes as a one. It raises `cv_o` for exactly one cycle, from the falling edge after the rising edge that sampled it.
- R6: A double mark raises `cv_o` with the timing of R5, decodes as a one, and leaves the last-mark polarity unchanged.
- R7: A substitution violation whose polarity equals that of the previous accepted substitution violation is rejected. It is flagged as in R5 and decoded as a one.
- R8: When `codec_en_i` is low at a rising edge, `nrz_o` follows `pos_i` with one cycle of lag, `cv_o` stays low, and the decoder state is cleared to its post-reset condition.
- R9: In both modes `rail_p_o` and `rail_n_o` repeat `pos_i` and `neg_i` with one cycle of lag.
- R10: With `OUT_ON_FALL=1` (default), outputs keep their old values just after a rising edge and change only at the following falling edge.
- R11: The first substitution violation after reset or bypass is accepted with either polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| codec_en_i | input | 1 | 1 = decode, 0 = rail bypass |
| pos_i | input | 1 | Positive-mark rail |
| neg_i | input | 1 | Negative-mark rail |
| nrz_o | output | 1 | Decoded NRZ data (bypass: delayed positive rail) |
| rail_p_o | output | 1 | Positive rail, one cycle late |
| rail_n_o | output | 1 | Negative rail, one cycle late |
| cv_o | output | 1 | Single-cycle coding-violation pulse |

## Verification
The bench builds the block with `WIN=4`, the group length the line code uses, and `OUT_ON_FALL=1`. With these values, the four-cycle data lag, the retroactive clearing of a balancing mark three positions back, and the falling-edge update timing can all be observed at the ports. Directed rail sequences cover both substitution forms, the alternation rule between successive violations, double marks, a first mark of negative polarity, and the state clearing that a bypass interval causes.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;

  typedef enum logic {
    POL_NEG = 1'b0,
    POL_POS = 1'b1
  } pol_e;

  // one delay-line entry
  typedef struct packed {
    logic mark;   // decodes as a one
    logic clean;  // single-rail mark (not a double mark)
    pol_e pol;
  } sym_t;

  typedef enum logic [2:0] {
    CLS_SPACE  = 3'd0,
    CLS_MARK   = 3'd1,
    CLS_SUB_Z  = 3'd2,  // zeros + violation
    CLS_SUB_B  = 3'd3,  // balancing mark + zeros + violation
    CLS_VIOL   = 3'd4,
    CLS_DOUBLE = 3'd5
  } cls_e;

endpackage

// File: rtl/hdb3_classify.sv
module hdb3_classify
  import hdb3_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic           pos,
  input  logic           neg,
  input  logic [WIN-2:0] win_mark,   // [0] newest
  input  sym_t           b_sym,      // oldest window entry
  input  pol_e           last_pol,
  input  logic           seen_mark,
  input  pol_e           last_v,
  input  logic           seen_v,
  output cls_e           cls
);

  pol_e pol;
  logic all_zero;
  logic b_fit;
  logic v_ok;

  always_comb begin
    pol      = pos ? POL_POS : POL_NEG;
    all_zero = ~|win_mark;
    b_fit    = (~|win_mark[WIN-3:0]) && b_sym.mark && b_sym.clean &&
               (b_sym.pol == pol);
    v_ok     = !seen_v || (pol != last_v);

    if (pos && neg)
      cls = CLS_DOUBLE;
    else if (!pos && !neg)
      cls = CLS_SPACE;
    else if (!seen_mark || (pol != last_pol))
      cls = CLS_MARK;
    else if (v_ok && all_zero)
      cls = CLS_SUB_Z;
    else if (v_ok && b_fit)
      cls = CLS_SUB_B;
    else
      cls = CLS_VIOL;
  end

endmodule

// File: rtl/hdb3_delay_line.sv
module hdb3_delay_line
  import hdb3_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  sym_t           sym_in,
  input  logic           kill_b,
  output logic [WIN-2:0] win_mark,
  output sym_t           b_sym,
  output logic           tail
);

  localparam int NSTG = WIN - 1;

  sym_t stg [NSTG];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NSTG; i++) stg[i] <= '0;
      tail <= 1'b0;
    end else begin
      stg[0] <= sym_in;
      for (int i = 1; i < NSTG; i++) stg[i] <= stg[i-1];
      tail <= kill_b ? 1'b0 : stg[NSTG-1].mark;
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_win
    assign win_mark[g] = stg[g].mark;
  end

  assign b_sym = stg[NSTG-1];

endmodule

// File: rtl/hdb3_out_stage.sv
module hdb3_out_stage #(
  parameter int  W           = 4,
  parameter bit  OUT_ON_FALL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (OUT_ON_FALL) begin : g_fall
    always_ff @(negedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
  end else begin : g_rise
    assign q = d;
  end

endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_pkg::*;
#(
  parameter int WIN         = 4,
  parameter bit OUT_ON_FALL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic codec_en_i,
  input  logic pos_i,
  input  logic neg_i,
  output logic nrz_o,
  output logic rail_p_o,
  output logic rail_n_o,
  output logic cv_o
);

  localparam int OW = 4;

  cls_e           cls;
  logic [WIN-2:0] win_mark;
  sym_t           b_sym;
  sym_t           sym_in;
  logic           tail;
  logic           kill_b;

  pol_e last_pol, last_v;
  logic seen_mark, seen_v;

  logic rail_p_q, rail_n_q, cv_q, en_q;
  logic [OW-1:0] out_d, out_q;

  hdb3_classify #(.WIN(WIN)) u_cls (
    .pos       (pos_i),
    .neg       (neg_i),
    .win_mark  (win_mark),
    .b_sym     (b_sym),
    .last_pol  (last_pol),
    .seen_mark (seen_mark),
    .last_v    (last_v),
    .seen_v    (seen_v),
    .cls       (cls)
  );

  always_comb begin
    sym_in.mark  = (cls == CLS_MARK) || (cls == CLS_VIOL) || (cls == CLS_DOUBLE);
    sym_in.clean = (cls != CLS_DOUBLE);
    sym_in.pol   = pos_i ? POL_POS : POL_NEG;
    kill_b       = (cls == CLS_SUB_B);
  end

  hdb3_delay_line #(.WIN(WIN)) u_dly (
    .clk      (clk),
    .rst      (rst),
    .clr      (!codec_en_i),
    .sym_in   (sym_in),
    .kill_b   (kill_b),
    .win_mark (win_mark),
    .b_sym    (b_sym),
    .tail     (tail)
  );

  // polarity tracking
  always_ff @(posedge clk) begin
    if (rst || !codec_en_i) begin
      last_pol  <= POL_NEG;
      last_v    <= POL_NEG;
      seen_mark <= 1'b0;
      seen_v    <= 1'b0;
    end else begin
      case (cls)
        CLS_MARK: begin
          last_pol  <= sym_in.pol;
          seen_mark <= 1'b1;
        end
        CLS_SUB_Z, CLS_SUB_B: begin
          last_pol <= sym_in.pol;
          last_v   <= sym_in.pol;
          seen_v   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // rising-edge result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rail_p_q <= 1'b0;
      rail_n_q <= 1'b0;
      cv_q     <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      rail_p_q <= pos_i;
      rail_n_q <= neg_i;
      en_q     <= codec_en_i;
      cv_q     <= codec_en_i && ((cls == CLS_VIOL) || (cls == CLS_DOUBLE));
    end
  end

  assign out_d = {en_q ? tail : rail_p_q, rail_p_q, rail_n_q, cv_q};

  hdb3_out_stage #(.W(OW), .OUT_ON_FALL(OUT_ON_FALL)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (out_d),
    .q   (out_q)
  );

  assign {nrz_o, rail_p_o, rail_n_o, cv_o} = out_q;

endmodule

// File: rtl/hdb3_rx_decoder_chk.sv
module hdb3_rx_decoder_chk (
  input logic clk,
  input logic rst,
  input logic codec_en_i,
  input logic pos_i,
  input logic neg_i,
  input logic nrz_o,
  input logic rail_p_o,
  input logic rail_n_o,
  input logic cv_o
);

  assert_rails_follow_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rail_p_o == $past(pos_i)) && (rail_n_o == $past(neg_i)));

  assert_double_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(codec_en_i && pos_i && neg_i)) |-> cv_o);

  assert_cv_needs_mark_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cv_o) |-> $past(pos_i || neg_i));

  assert_bypass_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!codec_en_i)) |-> !cv_o);

  assert_bypass_data_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!codec_en_i)) |-> (nrz_o == $past(pos_i)));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !cv_o);

endmodule

bind hdb3_rx_decoder hdb3_rx_decoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .codec_en_i (codec_en_i),
  .pos_i      (pos_i),
  .neg_i      (neg_i),
  .nrz_o      (nrz_o),
  .rail_p_o   (rail_p_o),
  .rail_n_o   (rail_n_o),
  .cv_o       (cv_o)
);

// File: tb/sim_hdb3_rx_decoder.sv
module sim_hdb3_rx_decoder;

  localparam int CLK_P = 10;
  localparam int WD_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic codec_en_i = 1'b1;
  logic pos_i = 1'b0;
  logic neg_i = 1'b0;
  logic nrz_o, rail_p_o, rail_n_o, cv_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  hdb3_rx_decoder #(.WIN(4), .OUT_ON_FALL(1'b1)) u0 (
    .clk        (clk),
    .rst        (rst),
    .codec_en_i (codec_en_i),
    .pos_i      (pos_i),
    .neg_i      (neg_i),
    .nrz_o      (nrz_o),
    .rail_p_o   (rail_p_o),
    .rail_n_o   (rail_n_o),
    .cv_o       (cv_o)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  // '+' positive, '-' negative, 'B' both rails, '0' space
  task automatic put(input byte c);
    pos_i = (c == "+") || (c == "B");
    neg_i = (c == "-") || (c == "B");
  endtask

  task automatic step(input byte c, input logic en);
    @(posedge clk); #1;
    put(c);
    codec_en_i = en;
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; put("0"); codec_en_i = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic run_seq(input string sym, input string exp_nrz,
                         input string exp_cv, input string tag);
    int n;
    n = sym.len();
    do_reset();
    for (int t = 0; t < n + 4; t++) begin
      byte c;
      byte pc;
      c = (t < n) ? sym[t] : "0";
      step(c, 1'b1);
      if (t >= 1 && t <= n) begin
        pc = sym[t-1];
        chk(cv_o, exp_cv[t-1] == "1", $sformatf("%s cv bit %0d", tag, t-1));
        chk(rail_p_o, (pc == "+") || (pc == "B"), $sformatf("R9 rail_p bit %0d (%s)", t-1, tag));
        chk(rail_n_o, (pc == "-") || (pc == "B"), $sformatf("R9 rail_n bit %0d (%s)", t-1, tag));
      end
      if (t >= 4)
        chk(nrz_o, exp_nrz[t-4] == "1", $sformatf("%s nrz bit %0d", tag, t-4));
    end
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    rst = 1'b1; put("B"); codec_en_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(nrz_o, 1'b0, "R1 reset nrz");
    chk(rail_p_o, 1'b0, "R1 reset rail_p");
    chk(rail_n_o, 1'b0, "R1 reset rail_n");
    chk(cv_o, 1'b0, "R1 reset cv");
  endtask

  task automatic t_alternate();
    run_seq("+-0+-00+", "11011001", "00000000", "R2");
  endtask

  task automatic t_first_neg();
    run_seq("-+-", "111", "000", "R1");
  endtask

  task automatic t_zero_group();
    run_seq("+000+-", "100001", "000000", "R3");
  endtask

  task automatic t_first_v_neg();
    run_seq("-000-+", "100001", "000000", "R11");
  endtask

  task automatic t_balance_group();
    run_seq("+000+-00-+", "1000000001", "0000000000", "R4");
  endtask

  task automatic t_bad_repeat();
    run_seq("+0+-", "1011", "0010", "R5");
  endtask

  task automatic t_double();
    run_seq("+B-", "111", "010", "R6");
  endtask

  task automatic t_v_same();
    run_seq("+000+-+000+", "10000110001", "00000000001", "R7");
  endtask

  task automatic t_bypass();
    string bp;
    bp = "+B0-+";
    do_reset();
    step("+", 1'b1);
    for (int i = 0; i < bp.len(); i++) begin
      step(bp[i], 1'b0);
      if (i >= 1) begin
        chk(nrz_o, (bp[i-1] == "+") || (bp[i-1] == "B"), $sformatf("R8 bypass nrz bit %0d", i-1));
        chk(cv_o, 1'b0, $sformatf("R8 bypass cv bit %0d", i-1));
        chk(rail_n_o, (bp[i-1] == "-") || (bp[i-1] == "B"), $sformatf("R9 bypass rail_n bit %0d", i-1));
      end
    end
    step("+", 1'b1);
    chk(nrz_o, 1'b1, "R8 bypass nrz last bit");
    step("0", 1'b1);
    chk(cv_o, 1'b0, "R8 state cleared, first mark after bypass");
    step("0", 1'b1);
    step("0", 1'b1);
    step("0", 1'b1);
    chk(nrz_o, 1'b1, "R8 decoded mark after bypass");
  endtask

  task automatic t_fall_edge();
    do_reset();
    step("+", 1'b1);
    step("0", 1'b1);
    chk(rail_p_o, 1'b1, "R10 rail_p after falling edge");
    @(posedge clk); #1;
    chk(rail_p_o, 1'b1, "R10 rail_p held after rising edge");
    @(negedge clk); #1;
    chk(rail_p_o, 1'b0, "R10 rail_p updated at falling edge");
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_alternate();
    t_first_neg();
    t_zero_group();
    t_first_v_neg();
    t_balance_group();
    t_bad_repeat();
    t_double();
    t_v_same();
    t_bypass();
    t_fall_edge();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule